// File: doc/BRIEF.md
# Programmable Digital Glitch Filter

This block cleans up the digital input lines of a multi-port input bank. Every raw line first passes through a synchroniser. After that, each line either goes straight to its output or goes through a glitch filter. A level is accepted only when it has stayed steady for a span set by one interval value. That one value is shared by every line of every port.

The host supplies the interval as a 32-bit word, of which only the low 20 bits take part. It also supplies one enable bit per line, grouped as an 8-bit mask for each port. A free-running counter produces sample ticks spaced interval+1 clocks apart. A filtered line moves to a new level only when two consecutive ticks both see that level and the synchronised input has not moved in between. Excursions shorter than that are dropped.

Top module: `deglitch_top`

## Requirements
- R1: After reset every bit of `filt_out` is 0, and the interval counter starts from 0.
- R2: A line whose bit in `line_en` is 0 shows its `raw_in` level on `filt_out` exactly two clocks later. That delay is the synchroniser.
- R3: With an interval of 0 there is a sample tick on every clock. An enabled line then shows a new steady input level four clocks after the change, and not before.
- R4: Only bits 19..0 of `interval_reg` set the interval. A value of 0xFFF00000 behaves exactly like 0.
- R5: With an interval of N, sample ticks are never more than N+1 clocks apart. On an enabled line, a pulse lasting no more than N+1 clocks never reaches `filt_out`.
- R6: An enabled line's output changes only in the clock that follows a sample tick. With an interval of 3, a held level is still absent six clocks after the input change and present twelve clocks after it.
- R7: Enables are per line. Within one port, an enabled line and a disabled line fed with the same edge each follow their own timing: 4 clocks and 2 clocks at an interval of 0.
- R8: The interval is shared by all ports. Line 0 of port 1 (bit 8) filters with the same 4-clock timing at an interval of 0 as the lines of port 0.
- R9: At an interval of 0, an input pulse of one clock on an enabled line is rejected. A pulse of two clocks passes: the output is high during the 4th and 5th clocks after its start and low again from the 6th.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Synchronous reset, active low |
| raw_in | input | NUM_PORTS*8 | Unsynchronised input lines; port p holds bits 8p+7..8p |
| line_en | input | NUM_PORTS*8 | Filter enable per line, one 8-bit mask per port, 1 = filtered |
| interval_reg | input | 32 | Shared filter interval; bits 19..0 are used |
| filt_out | output | NUM_PORTS*8 | Filtered or bypassed line levels |

## Verification
Several properties are checked on every clock. Outputs are cleared when reset is released. Disabled lines lag the raw input by exactly two clocks. Sample ticks are never spaced wider than the interval allows. An enabled output never moves except right after a tick. Other behaviour can only be shown by the bench's scenarios: rejection of short pulses, the exact four-clock latency at interval 0, the early and late bounds at interval 3, the masking of the upper interval bits, and the independence of lines and ports.

// File: rtl/deglitch_pkg.sv
// Shared sizing constants for the glitch filter.
// Assumes an 8-line port and a 20-bit effective interval inside a 32-bit word.
package deglitch_pkg;
    localparam int unsigned DG_LINES_PER_PORT = 8;
    localparam int unsigned DG_IVL_W          = 20;
    localparam int unsigned DG_REG_W          = 32;
    localparam int unsigned DG_SYNC_STAGES    = 2;
endpackage

// File: rtl/deglitch_sync.sv
// Multi-stage synchroniser for a vector of asynchronous lines.
// Assumes STAGES >= 1. The lines are treated independently; no bus coherence is implied.
module deglitch_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the raw sample through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/deglitch_tick.sv
// Shared sample tick generator.
// The counter runs freely. A tick is raised whenever the count has reached the
// interval, and the count then restarts at 0. Comparing with >= keeps the
// spacing bounded when the interval is lowered below the current count.
module deglitch_tick #(
    parameter int unsigned IVL_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IVL_W-1:0] interval,
    output logic             tick
);
    logic [IVL_W-1:0] cnt_q;

    assign tick = (cnt_q >= interval);

    // Advance the interval counter, restarting after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/deglitch_line.sv
// Per-line glitch filter state.
// At each tick the synchronised level is captured as a candidate. The held
// output takes the candidate only if the next tick sees the same level and
// the level did not move in between. With the enable low, the synchronised
// level is passed straight through.
module deglitch_line (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sync_in,
    input  logic en,
    output logic y
);
    logic held_q;
    logic cand_q;
    logic steady_q;

    // Track the candidate level and confirm it on a second tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q   <= 1'b0;
            cand_q   <= 1'b0;
            steady_q <= 1'b0;
        end else if (tick) begin
            if (steady_q && (sync_in == cand_q)) begin
                held_q <= sync_in;
            end
            cand_q   <= sync_in;
            steady_q <= 1'b1;
        end else if (sync_in != cand_q) begin
            steady_q <= 1'b0;
        end
    end

    assign y = en ? held_q : sync_in;
endmodule

// File: rtl/deglitch_top.sv
// Glitch filter for NUM_PORTS ports of LINES_PER_PORT lines.
// Assumes raw_in is asynchronous. line_en and interval_reg are quasi-static
// host values. One tick generator serves every line of every port.
module deglitch_top
    import deglitch_pkg::*;
#(
    parameter int unsigned NUM_PORTS      = 2,
    parameter int unsigned LINES_PER_PORT = DG_LINES_PER_PORT,
    parameter int unsigned IVL_W          = DG_IVL_W,
    parameter int unsigned REG_W          = DG_REG_W,
    parameter int unsigned SYNC_STAGES    = DG_SYNC_STAGES,
    localparam int unsigned NUM_LINES     = NUM_PORTS * LINES_PER_PORT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] raw_in,
    input  logic [NUM_LINES-1:0] line_en,
    input  logic [REG_W-1:0]     interval_reg,
    output logic [NUM_LINES-1:0] filt_out
);
    logic [NUM_LINES-1:0] sync_q;
    logic [IVL_W-1:0]     ivl_lo;
    logic                 tick;
    logic                 unused_ivl_hi;

    assign ivl_lo        = interval_reg[IVL_W-1:0];
    assign unused_ivl_hi = ^interval_reg[REG_W-1:IVL_W];

    deglitch_sync #(
        .W      (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_q)
    );

    deglitch_tick #(
        .IVL_W (IVL_W)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .interval (ivl_lo),
        .tick     (tick)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        deglitch_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .sync_in (sync_q[i]),
            .en      (line_en[i]),
            .y       (filt_out[i])
        );
    end
endmodule

// File: rtl/deglitch_chk.sv
// Assertion checker for deglitch_top, attached by bind.
// Assumes the two-stage synchroniser for the bypass-lag property.
module deglitch_chk #(
    parameter int unsigned NUM_LINES   = 16,
    parameter int unsigned IVL_W       = 20,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] raw_in,
    input logic [NUM_LINES-1:0] line_en,
    input logic [NUM_LINES-1:0] filt_out,
    input logic [IVL_W-1:0]     ivl,
    input logic                 tick
);
    logic [1:0]     since_rst;
    logic [IVL_W:0] gap_q;

    // Count clocks since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // Count clocks since the most recent tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    gap_q <= '0;
        else if (tick) gap_q <= '0;
        else           gap_q <= gap_q + 1'b1;
    end

    // R1: outputs clear as reset is released.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (filt_out == '0));

    // R5: tick spacing never exceeds the interval plus one.
    a_r5_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |-> ({1'b0, ivl} > gap_q));

    // R6: enabled outputs move only right after a tick.
    a_r6_change_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst != 2'd0) && (line_en == $past(line_en)) && !$past(tick))
        |-> ((filt_out & line_en) == ($past(filt_out) & line_en)));

    if (SYNC_STAGES == 2) begin : g_bypass
        // R2: disabled lines repeat the raw input two clocks late.
        a_r2_bypass_lag: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 2'd2) |-> ((filt_out & ~line_en) == ($past(raw_in, 2) & ~line_en)));
    end
endmodule

bind deglitch_top deglitch_chk #(
    .NUM_LINES   (NUM_LINES),
    .IVL_W       (IVL_W),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (raw_in),
    .line_en  (line_en),
    .filt_out (filt_out),
    .ivl      (ivl_lo),
    .tick     (tick)
);

// File: tb/tb_deglitch_top.sv
// Scoreboard bench: the driver queues expected output values per cycle; the monitor compares them.
module tb_deglitch_top;
    localparam int NL = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] raw_in = '0;
    logic [NL-1:0] line_en = '0;
    logic [31:0]   interval_reg = '0;
    logic [NL-1:0] filt_out;

    always #2 clk = ~clk;

    deglitch_top dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .raw_in       (raw_in),
        .line_en      (line_en),
        .interval_reg (interval_reg),
        .filt_out     (filt_out)
    );

    typedef struct {
        int            cyc;
        logic [NL-1:0] mask;
        logic [NL-1:0] val;
        string         tag;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    task automatic expect_at(int dly, logic [NL-1:0] m, logic [NL-1:0] v, string tag);
        exp_t e;
        e.cyc = cyc + dly; e.mask = m; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: after each rising edge, compare the due scoreboard items.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            cyc++;
            #1;
            while (sb.size() > 0 && sb[0].cyc <= cyc) begin
                e = sb.pop_front();
                checks++;
                if (e.cyc != cyc || (filt_out & e.mask) !== (e.val & e.mask)) begin
                    errors++;
                    $display("FAIL %s cycle %0d actual %h expected %h",
                             e.tag, cyc, filt_out & e.mask, e.val & e.mask);
                end
            end
        end
    end

    // Driver.
    initial begin
        step(5);
        rst_n = 1'b1;
        expect_at(1, '1, '0, "R1");
        expect_at(3, '1, '0, "R1");
        step(6);

        // R2, R3, R7: line 0 filtered, line 1 bypassed, interval 0, rising edge.
        line_en = 16'h0001;
        step(4);
        raw_in[1:0] = 2'b11;
        expect_at(1, 16'h0003, 16'h0000, "R2");
        expect_at(2, 16'h0002, 16'h0002, "R2");
        expect_at(2, 16'h0001, 16'h0000, "R7");
        expect_at(3, 16'h0001, 16'h0000, "R3");
        expect_at(4, 16'h0003, 16'h0003, "R3");
        step(10);
        // Falling edge on the same pair.
        raw_in[1:0] = 2'b00;
        expect_at(1, 16'h0003, 16'h0003, "R2");
        expect_at(2, 16'h0002, 16'h0000, "R2");
        expect_at(2, 16'h0001, 16'h0001, "R7");
        expect_at(3, 16'h0001, 16'h0001, "R3");
        expect_at(4, 16'h0003, 16'h0000, "R7");
        step(10);

        // R8: port 1 line 0 shares the interval.
        line_en[8] = 1'b1;
        step(4);
        raw_in[8] = 1'b1;
        expect_at(3, 16'h0100, 16'h0000, "R8");
        expect_at(4, 16'h0100, 16'h0100, "R8");
        step(10);

        // R4: upper interval bits are ignored.
        interval_reg = 32'hFFF0_0000;
        line_en[2] = 1'b1;
        step(4);
        raw_in[2] = 1'b1;
        expect_at(3, 16'h0004, 16'h0000, "R4");
        expect_at(4, 16'h0004, 16'h0004, "R4");
        step(10);
        interval_reg = 32'h0;

        // R9: one-clock pulse rejected at interval 0.
        line_en[3] = 1'b1;
        step(4);
        raw_in[3] = 1'b1;
        for (int k = 1; k <= 8; k++) expect_at(k, 16'h0008, 16'h0000, "R9");
        step(1);
        raw_in[3] = 1'b0;
        step(10);
        // R9: two-clock pulse passes.
        raw_in[3] = 1'b1;
        expect_at(3, 16'h0008, 16'h0000, "R9");
        expect_at(4, 16'h0008, 16'h0008, "R9");
        expect_at(5, 16'h0008, 16'h0008, "R9");
        expect_at(6, 16'h0008, 16'h0000, "R9");
        step(2);
        raw_in[3] = 1'b0;
        step(10);

        // R5: interval 3, a four-clock pulse never appears.
        interval_reg = 32'd3;
        line_en[4] = 1'b1;
        step(20);
        raw_in[4] = 1'b1;
        for (int k = 1; k <= 24; k++) expect_at(k, 16'h0010, 16'h0000, "R5");
        step(4);
        raw_in[4] = 1'b0;
        step(26);

        // R6: held level bounded between 6 and 12 clocks at interval 3.
        raw_in[4] = 1'b1;
        expect_at(6, 16'h0010, 16'h0000, "R6");
        expect_at(12, 16'h0010, 16'h0010, "R6");
        step(20);
        raw_in[4] = 1'b0;
        expect_at(6, 16'h0010, 16'h0010, "R6");
        expect_at(12, 16'h0010, 16'h0000, "R6");
        step(20);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule